// File: doc/BRIEF.md
# In-Order Store Writeback Scheduler

This block holds stores that have left the pipeline in a circular queue and drains them, oldest first, to a data cache request channel. Each slot records whether it holds a store, whether the store may write back, whether it has zero size, whether it is split into two halves, whether it has been sent and whether the cache has finished it. A commit input marks every store up to a given sequence number as ready to write back. A writeback pointer then walks the queue in order and sends each ready store over a valid/ready channel. A split store sends a lower half and then an upper half. A store of zero size finishes on the spot without reaching the cache.

The channel carries one request per cycle. A refused request stays on the channel unchanged until it is taken, and nothing behind it moves in the meantime. An optional ordering mode lets only one store be outstanding at the cache. Completion responses name a slot. The head pointer frees slots only across an unbroken run of finished stores, so a store that finishes early is held until every older store has finished too. One slot is always left empty, so the number of free slots is the slot count minus occupancy minus one.

Top module: `sqw_top`

## Requirements
- R1: After reset, req_valid is 0, free_cnt equals DEPTH-1 and head_idx is 0.
- R2: At most DEPTH-1 stores are held. free_cnt equals DEPTH-1 minus the number held. An allocation offered while free_cnt is 0 is ignored. Slots are assigned in allocation order 0,1,2,… modulo DEPTH.
- R3: Only stores whose sequence number is less than or equal to a committed sequence number are sent. They are sent in allocation order, and req_idx carries the slot number.
- R4: A split store is sent as two consecutive accepted requests on the same slot: first with req_second=0, then with req_second=1.
- R5: A zero-size store never appears on the request channel. It completes by itself and its slot is freed in order.
- R6: While req_valid=1 and req_ready=0, the next cycle still shows req_valid=1 with the same req_idx and req_second, and no other store advances.
- R7: With tso_en=1, the first half of a new store is not accepted while an earlier sent store still has no response, and no store is taken from the queue while one is in flight.
- R8: A response marks its slot finished. head_idx and free_cnt advance only across a contiguous run of finished slots starting at the head. Several slots may retire in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tso_en | input | 1 | Allow only one store outstanding at the cache |
| alloc_valid | input | 1 | Append a store at the tail |
| alloc_zero | input | 1 | Appended store has zero size |
| alloc_split | input | 1 | Appended store needs two requests |
| alloc_seq | input | 16 | Sequence number of the appended store |
| commit_valid | input | 1 | Commit stores up to commit_seq |
| commit_seq | input | 16 | Youngest committed sequence number |
| req_valid | output | 1 | Cache request present |
| req_idx | output | $clog2(DEPTH) | Slot of the requesting store |
| req_second | output | 1 | Request is the upper half of a split store |
| req_ready | input | 1 | Cache accepts the request |
| rsp_valid | input | 1 | Completion response |
| rsp_idx | input | $clog2(DEPTH) | Slot completed by the response |
| free_cnt | output | $clog2(DEPTH+1) | Free slots |
| head_idx | output | $clog2(DEPTH) | Oldest held slot |

## Verification
A wrong writeback pointer or a lost commit mark shows up on the first accepted request: its slot or half no longer matches the allocation order, or a request appears before its commit. A damaged request register shows up within one cycle under backpressure, as a changed slot or a dropped valid. A wrong finished bit or a wrong retire count shows up as free_cnt or head_idx drifting from the count the bench expects. The bench checks both at every drain point, and during an out-of-order response test it checks them while an older store is still outstanding.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    localparam int SEQ_W = 16;

    typedef logic [SEQ_W-1:0] seq_t;

    // One queue slot
    typedef struct packed {
        logic valid;
        logic can_wb;
        logic zero;
        logic split;
        logic issued;
        logic done;
        seq_t seq;
    } sq_entry_t;

    // Request register tag
    typedef struct packed {
        logic valid;
        logic second;
        logic split;
    } req_tag_t;

    function automatic logic seq_covered(seq_t s, seq_t limit);
        return s <= limit;
    endfunction

endpackage

// File: rtl/sqw_issue.sv
module sqw_issue import sqw_pkg::*; #(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cand_ok,
    input  logic          cand_zero,
    input  logic          cand_split,
    input  logic [IW-1:0] wb_idx,
    input  logic          req_ready,
    output logic          req_valid,
    output logic [IW-1:0] req_idx,
    output logic          req_second,
    output logic          take,
    output logic          zero_done
);

    req_tag_t      tag_q, tag_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          slot_free;
    logic          need_second;

    assign slot_free   = !tag_q.valid || req_ready;
    assign need_second = tag_q.valid && req_ready && tag_q.split && !tag_q.second;

    always_comb begin
        take      = 1'b0;
        zero_done = 1'b0;
        tag_d     = tag_q;
        idx_d     = idx_q;
        if (slot_free) begin
            tag_d.valid = 1'b0;
            if (need_second) begin
                tag_d = '{valid: 1'b1, second: 1'b1, split: 1'b1};
            end else if (cand_ok) begin
                take = 1'b1;
                if (cand_zero) begin
                    zero_done = 1'b1;
                end else begin
                    tag_d = '{valid: 1'b1, second: 1'b0, split: cand_split};
                    idx_d = wb_idx;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            idx_q <= '0;
        end else begin
            tag_q <= tag_d;
            idx_q <= idx_d;
        end
    end

    assign req_valid  = tag_q.valid;
    assign req_idx    = idx_q;
    assign req_second = tag_q.second;

endmodule

// File: rtl/sqw_retire.sv
module sqw_retire #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input  logic [IW-1:0]    head,
    input  logic [DEPTH-1:0] done_vec,
    output logic [CW-1:0]    n_ret,
    output logic [DEPTH-1:0] ret_mask
);

    always_comb begin
        logic run;
        int   p;
        run      = 1'b1;
        n_ret    = '0;
        ret_mask = '0;
        for (int k = 0; k < DEPTH; k++) begin
            p = (int'(head) + k) % DEPTH;
            if (run && done_vec[p]) begin
                ret_mask[p] = 1'b1;
                n_ret       = n_ret + CW'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/sqw_top.sv
module sqw_top import sqw_pkg::*; #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tso_en,
    input  logic                       alloc_valid,
    input  logic                       alloc_zero,
    input  logic                       alloc_split,
    input  logic [SEQ_W-1:0]           alloc_seq,
    input  logic                       commit_valid,
    input  logic [SEQ_W-1:0]           commit_seq,
    output logic                       req_valid,
    output logic [$clog2(DEPTH)-1:0]   req_idx,
    output logic                       req_second,
    input  logic                       req_ready,
    input  logic                       rsp_valid,
    input  logic [$clog2(DEPTH)-1:0]   rsp_idx,
    output logic [$clog2(DEPTH+1)-1:0] free_cnt,
    output logic [$clog2(DEPTH)-1:0]   head_idx
);

    localparam int IW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH+1);
    localparam int CAP = DEPTH - 1;

    function automatic logic [IW-1:0] ptr_inc(logic [IW-1:0] p);
        return (int'(p) == DEPTH-1) ? '0 : p + IW'(1);
    endfunction

    sq_entry_t        q [DEPTH];
    logic [IW-1:0]    head_q, tail_q, wb_q;
    logic [CW-1:0]    occ_q;
    logic             inflight_q;
    logic             alloc_ok;
    logic             cand_ok;
    logic             take, zero_done;
    logic [DEPTH-1:0] done_vec, ret_mask;
    logic [CW-1:0]    n_ret;

    assign alloc_ok = alloc_valid && (occ_q != CW'(CAP));
    assign cand_ok  = (wb_q != tail_q) && q[wb_q].valid && q[wb_q].can_wb
                      && !(tso_en && inflight_q);

    sqw_issue #(.IW(IW)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .cand_ok    (cand_ok),
        .cand_zero  (q[wb_q].zero),
        .cand_split (q[wb_q].split),
        .wb_idx     (wb_q),
        .req_ready  (req_ready),
        .req_valid  (req_valid),
        .req_idx    (req_idx),
        .req_second (req_second),
        .take       (take),
        .zero_done  (zero_done)
    );

    sqw_retire #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_retire (
        .head     (head_q),
        .done_vec (done_vec),
        .n_ret    (n_ret),
        .ret_mask (ret_mask)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign done_vec[i] = q[i].valid && q[i].done;

        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (ret_mask[i]) begin
                q[i] <= '0;
            end else if (alloc_ok && tail_q == IW'(i)) begin
                q[i] <= '{valid: 1'b1, can_wb: 1'b0, zero: alloc_zero,
                          split: alloc_split, issued: 1'b0, done: 1'b0,
                          seq: alloc_seq};
            end else begin
                if (commit_valid && q[i].valid && seq_covered(q[i].seq, commit_seq))
                    q[i].can_wb <= 1'b1;
                if (take && wb_q == IW'(i)) begin
                    q[i].issued <= 1'b1;
                    if (zero_done)
                        q[i].done <= 1'b1;
                end
                if (rsp_valid && rsp_idx == IW'(i) && q[i].issued)
                    q[i].done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q     <= '0;
            tail_q     <= '0;
            wb_q       <= '0;
            occ_q      <= '0;
            inflight_q <= 1'b0;
        end else begin
            if (alloc_ok)
                tail_q <= ptr_inc(tail_q);
            if (take)
                wb_q <= ptr_inc(wb_q);
            head_q <= IW'((int'(head_q) + int'(n_ret)) % DEPTH);
            occ_q  <= occ_q + CW'(alloc_ok) - n_ret;
            if (take && !zero_done)
                inflight_q <= 1'b1;
            else if (rsp_valid)
                inflight_q <= 1'b0;
        end
    end

    assign free_cnt = CW'(CAP) - occ_q;
    assign head_idx = head_q;

endmodule

// File: rtl/sqw_chk.sv
module sqw_chk #(
    parameter int DEPTH = 8,
    parameter int IW    = 3,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          tso_en,
    input logic          req_valid,
    input logic          req_ready,
    input logic [IW-1:0] req_idx,
    input logic          req_second,
    input logic          req_split,
    input logic [CW-1:0] occ,
    input logic          inflight,
    input logic          take,
    input logic [CW-1:0] n_ret,
    input logic          head_done
);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_idx) && $stable(req_second));

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH-1));

    // R4
    split_pair_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !req_second && req_split
        |=> req_valid && req_second && req_idx == $past(req_idx));

    // R7
    tso_single_chk: assert property (@(posedge clk) disable iff (rst)
        tso_en && inflight |-> !take);

    // R8
    head_run_chk: assert property (@(posedge clk) disable iff (rst)
        n_ret != '0 |-> head_done);

endmodule

bind sqw_top sqw_chk #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tso_en     (tso_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_idx    (req_idx),
    .req_second (req_second),
    .req_split  (q[req_idx].split),
    .occ        (occ_q),
    .inflight   (inflight_q),
    .take       (take),
    .n_ret      (n_ret),
    .head_done  (q[head_q].done)
);

// File: tb/sim_sqw_top.sv
module sim_sqw_top;
    import sqw_pkg::*;

    localparam int DEPTH = 8;
    localparam int CAP   = DEPTH - 1;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH+1);

    logic clk = 0, rst = 1, tso_en = 0;
    logic alloc_valid = 0, alloc_zero = 0, alloc_split = 0;
    logic [SEQ_W-1:0] alloc_seq = '0, commit_seq = '0;
    logic commit_valid = 0, req_ready = 0, rsp_valid = 0;
    logic [IW-1:0] rsp_idx = '0;
    logic req_valid, req_second;
    logic [IW-1:0] req_idx, head_idx;
    logic [CW-1:0] free_cnt;

    always #4 clk = ~clk;

    sqw_top #(.DEPTH(DEPTH)) u0 (.*);

    int checks = 0, errors = 0;
    int n_alloc = 0, n_commit = 0, outstanding = 0, acc_cnt = 0;
    bit m_zero [int];
    bit m_split [int];
    int exp_q [$];
    int pend_q [$];
    bit auto_rsp = 1, rand_rdy = 0, hold_low = 0, man_go = 0, done_flag = 0;
    int man_idx = 0;
    bit prev_stall = 0;
    int prev_idx = 0, prev_sec = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code(int slot, int sec, int last);
        return slot * 4 + sec * 2 + last;
    endfunction

    // response and ready driver
    always @(posedge clk) begin
        #2;
        if (man_go) begin
            rsp_valid = 1; rsp_idx = IW'(man_idx); man_go = 0;
        end else if (auto_rsp && pend_q.size() > 0 && ($urandom % 3) == 0) begin
            rsp_valid = 1; rsp_idx = IW'(pend_q.pop_front());
        end else begin
            rsp_valid = 0;
        end
        req_ready = hold_low ? 1'b0 : (rand_rdy ? (($urandom % 4) != 0) : 1'b1);
    end

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) outstanding--;
            if (prev_stall)
                chk(req_valid && int'(req_idx) == prev_idx && int'(req_second) == prev_sec,
                    "R6 held request", int'(req_idx), prev_idx);
            if (req_valid && req_ready) begin
                int e;
                acc_cnt++;
                if (exp_q.size() == 0) begin
                    chk(0, "R3 unexpected request", int'(req_idx), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(code(int'(req_idx), int'(req_second), 0) == (e & ~1),
                        "R3 R4 request order", code(int'(req_idx), int'(req_second), 0), e & ~1);
                    if (tso_en && !req_second)
                        chk(outstanding == 0, "R7 single in flight", outstanding, 0);
                    if (e % 2 == 1) begin
                        pend_q.push_back(e / 4);
                        outstanding++;
                    end
                end
            end
            prev_stall = req_valid && !req_ready;
            prev_idx   = int'(req_idx);
            prev_sec   = int'(req_second);
        end
    end

    task automatic cyc();
        @(posedge clk); #3;
    endtask

    task automatic do_alloc(bit z, bit s);
        alloc_valid = 1; alloc_zero = z; alloc_split = s;
        alloc_seq = SEQ_W'(n_alloc + 1);
        if (free_cnt != 0) begin
            m_zero[n_alloc] = z; m_split[n_alloc] = s; n_alloc++;
        end
        cyc();
        alloc_valid = 0;
    endtask

    task automatic do_commit(int upto);
        commit_valid = 1; commit_seq = SEQ_W'(upto);
        while (n_commit < upto && n_commit < n_alloc) begin
            int slot = n_commit % DEPTH;
            if (!m_zero[n_commit]) begin
                if (m_split[n_commit]) begin
                    exp_q.push_back(code(slot, 0, 0));
                    exp_q.push_back(code(slot, 1, 1));
                end else begin
                    exp_q.push_back(code(slot, 0, 1));
                end
            end
            n_commit++;
        end
        cyc();
        commit_valid = 0;
    endtask

    task automatic drain(string tag);
        int t = 0;
        do_commit(n_alloc);
        hold_low = 0;
        while (!(exp_q.size() == 0 && outstanding == 0 && int'(free_cnt) == CAP) && t < 3000) begin
            cyc(); t++;
        end
        chk(int'(free_cnt) == CAP, {"R8 drained free ", tag}, int'(free_cnt), CAP);
        chk(int'(head_idx) == n_alloc % DEPTH, {"R8 drained head ", tag}, int'(head_idx), n_alloc % DEPTH);
    endtask

    task automatic random_phase(int n);
        for (int c = 0; c < n; c++) begin
            int r = $urandom % 8;
            if (r < 3) do_alloc(($urandom % 5) == 0, ($urandom % 3) == 0);
            else if (r == 3) do_commit(n_alloc);
            else cyc();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int a0, b0, acc0;
        void'($urandom(32'd2024));
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R1 reset state
        chk(req_valid == 0, "R1 req_valid", int'(req_valid), 0);
        chk(int'(free_cnt) == CAP, "R1 free_cnt", int'(free_cnt), CAP);
        chk(int'(head_idx) == 0, "R1 head_idx", int'(head_idx), 0);

        // R2 fill past capacity
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(0, 0);
            chk(int'(free_cnt) == ((i + 1 < CAP) ? CAP - i - 1 : 0), "R2 free_cnt",
                int'(free_cnt), (i + 1 < CAP) ? CAP - i - 1 : 0);
        end
        chk(n_alloc == CAP, "R2 extra alloc ignored", n_alloc, CAP);
        for (int i = 0; i < 5; i++) begin
            cyc();
            chk(req_valid == 0, "R3 nothing before commit", int'(req_valid), 0);
        end

        // R3 partial commit
        do_commit(3);
        repeat (30) cyc();
        chk(exp_q.size() == 0 && req_valid == 0, "R3 partial commit stops", int'(req_valid), 0);
        chk(acc_cnt == 3, "R3 three requests", acc_cnt, 3);
        drain("fill");

        // R4 split stores
        do_alloc(0, 1); do_alloc(0, 1); do_alloc(0, 0);
        drain("split");

        // R5 zero-size stores
        acc0 = acc_cnt;
        do_alloc(1, 0); do_alloc(1, 0); do_alloc(1, 0);
        drain("zero");
        chk(acc_cnt == acc0, "R5 zero-size no request", acc_cnt - acc0, 0);

        // R6 backpressure
        hold_low = 1;
        a0 = n_alloc % DEPTH;
        do_alloc(0, 0); do_alloc(1, 0); do_alloc(0, 0);
        do_commit(n_alloc);
        repeat (10) cyc();
        chk(req_valid == 1 && int'(req_idx) == a0, "R6 held under backpressure", int'(req_idx), a0);
        chk(exp_q.size() == 2, "R6 nothing accepted", exp_q.size(), 2);
        chk(int'(free_cnt) == CAP - 3, "R6 no retire while blocked", int'(free_cnt), CAP - 3);
        drain("hold");

        // R8 out-of-order completion
        auto_rsp = 0;
        a0 = n_alloc % DEPTH;
        do_alloc(0, 0);
        b0 = n_alloc % DEPTH;
        do_alloc(0, 0);
        do_commit(n_alloc);
        repeat (10) cyc();
        chk(exp_q.size() == 0, "R8 both sent", exp_q.size(), 0);
        man_idx = b0; man_go = 1;
        repeat (5) cyc();
        chk(int'(free_cnt) == CAP - 2, "R8 younger done waits", int'(free_cnt), CAP - 2);
        chk(int'(head_idx) == a0, "R8 head stays", int'(head_idx), a0);
        man_idx = a0; man_go = 1;
        repeat (5) cyc();
        chk(int'(free_cnt) == CAP, "R8 run retires together", int'(free_cnt), CAP);
        chk(int'(head_idx) == n_alloc % DEPTH, "R8 head after run", int'(head_idx), n_alloc % DEPTH);
        pend_q.delete();
        auto_rsp = 1;

        // R7 ordered mode, random traffic
        rand_rdy = 1;
        tso_en = 1;
        random_phase(600);
        drain("tso");
        tso_en = 0;
        random_phase(600);
        drain("free");

        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule